// File: doc/BRIEF.md
# Watchdog and Reset Pulse Controller

This block collects the internal reset sources of a small 8-bit microcontroller and turns them into a single active-low reset output. A free-running watchdog counter advances on each bus-cycle enable. Software keeps it from expiring by writing a zero into the service bit of a fixed control register on the write bus. If the watchdog expires while the nonvolatile enable input allows it, or if the supply-voltage detector reports a low supply, the block drives its reset output low. Each such pulse lasts three to four bus cycles.

The same control register also holds two option bits, a security lock and an optional-feature enable, and the block presents both as outputs. A pair of source flags records which source caused the latest reset pulse. These flags survive the pulses and are cleared only by power-on reset. An external synchronous reset input holds the watchdog at zero while it is low.

Top module: `wdg_rst_ctrl`

## Requirements
- R1: With `wdg_enable` = 1 and no service, `rst_out_n` falls `TIMEOUT_CYC` bus-cycle enables after the watchdog counter last restarted.
- R2: A write with `wr_en` = 1, `wr_addr` = 0x1FF0 and `wr_data` bit 0 = 0 restarts the watchdog count from zero.
- R3: A write to 0x1FF0 with `wr_data` bit 0 = 1 leaves the watchdog count unchanged, and so does a write to any other address.
- R4: A single reset request drives `rst_out_n` low for at least 3 and at most 4 bus cycles, and the pulse ends only on a bus-cycle enable.
- R5: With `wdg_enable` = 0, watchdog expiry never drives `rst_out_n` low.
- R6: `lv_detect` = 1 (supply below trip level) produces a reset pulse with the same width rules as R4. While `lv_detect` stays high, `rst_out_n` stays low.
- R7: A request that arrives while a pulse is active extends the pulse, so that at least three full bus cycles remain after the request.
- R8: The watchdog count restarts from zero after every reset pulse, and is held at zero while `ext_rst_n` is low.
- R9: `src_wdg` / `src_lv` show the source of the latest reset pulse, with at most one of them set and low voltage winning a tie. They keep their value across pulses and clear only on `por_n`.
- R10: A write to 0x1FF0 copies `wr_data` bit 7 into `sec_lock` and bit 6 into `opt_feat_en` (1 = enabled). Reset pulses leave both unchanged, and `por_n` clears both.
- R11: After power-on reset, `rst_out_n` = 1 and `src_wdg`, `src_lv`, `opt_feat_en` and `sec_lock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| ext_rst_n | input | 1 | External synchronous reset, holds watchdog at zero when low |
| bus_ce | input | 1 | One-clock enable marking each bus cycle |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| wdg_enable | input | 1 | Nonvolatile option: 1 lets watchdog expiry cause reset |
| lv_detect | input | 1 | Low-supply comparator output, 1 = below trip |
| rst_out_n | output | 1 | Active-low reset pulse output |
| src_wdg | output | 1 | Latest pulse came from the watchdog |
| src_lv | output | 1 | Latest pulse came from low voltage |
| opt_feat_en | output | 1 | Optional-feature enable bit |
| sec_lock | output | 1 | Security lock bit |

## Verification
A register write takes effect on the clock edge that captures it, so the option bits and the restarted count can be observed at the next falling-edge sample. Watchdog expiry is due `TIMEOUT_CYC` bus cycles after the restart edge. Because the bench divides the clock by two, it accepts a fall within one bus cycle of that instant. A low-voltage request passes two synchronizer stages and the pulse register first, so the bench measures pulse widths from the first low sample and extension lengths from the stimulus edge plus that latency. All sampling happens on falling edges, while inputs are driven at falling edges and held through the next rising edge.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  // Control register location; decoded against the write bus.
  localparam logic [15:0] CTRL_REG_ADDR = 16'h1FF0;
  // Bit positions inside the control register.
  localparam int unsigned SVC_BIT = 0;  // write 0 to restart watchdog
  localparam int unsigned OPT_BIT = 6;  // optional-feature enable
  localparam int unsigned SEC_BIT = 7;  // security lock

  typedef struct packed {
    logic wdg;
    logic lv;
  } src_flags_t;
endpackage

// File: rtl/wrc_sync.sv
module wrc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sr_d = d;
    end else begin : g_chain
      always_comb sr_d = {sr_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/wrc_wdg_timer.sv
module wrc_wdg_timer #(
  parameter int TIMEOUT_CYC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic hold,
  input  logic service,
  output logic expire
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (hold || service) begin
      cnt_d = '0;
    end else if (ce) begin
      if (at_last) begin
        cnt_d  = '0;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r2_service_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> (cnt_q == '0));
  a_r8_hold_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
  a_r3_idle_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !hold && !service) |=> $stable(cnt_q));
endmodule

// File: rtl/wrc_pulse_gen.sv
module wrc_pulse_gen #(
  parameter int PULSE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic req,
  output logic active,
  output logic rst_out_n
);
  // One extra count covers the partial bus cycle in which the request lands.
  localparam int LOAD = PULSE_CYC + 1;
  localparam int PW   = $clog2(LOAD + 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (req)                      cnt_d = PW'(LOAD);
    else if (ce && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active    = (cnt_q != '0);
  assign rst_out_n = ~active;

  a_r4_low_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !rst_out_n);
  a_r4_release_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(ce));
  a_r7_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && !ce) |=> !rst_out_n);
endmodule

// File: rtl/wdg_rst_ctrl.sv
module wdg_rst_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 32768,
  parameter int PULSE_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              bus_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wdg_enable,
  input  logic              lv_detect,
  output logic              rst_out_n,
  output logic              src_wdg,
  output logic              src_lv,
  output logic              opt_feat_en,
  output logic              sec_lock
);
  import wrc_pkg::*;

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_REG_ADDR);

  logic rst_n;
  logic lv_s;
  logic reg_hit;
  logic service;
  logic pulse_active;
  logic wdg_hold;
  logic wdg_expire;
  logic wdg_req;
  logic any_req;

  src_flags_t flags_q, flags_d;
  logic       opt_q, opt_d;
  logic       sec_q, sec_d;

  // Power-on reset: asynchronous assert, synchronous release.
  wrc_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(rst_n)
  );

  // Comparator output arrives asynchronously.
  wrc_sync #(.STAGES(SYNC_STAGES)) u_lv_sync (
    .clk(clk), .arst_n(rst_n), .d(lv_detect), .q(lv_s)
  );

  assign reg_hit  = wr_en && (wr_addr == HIT_ADDR);
  assign service  = reg_hit && !wr_data[SVC_BIT];
  assign wdg_hold = !ext_rst_n || pulse_active;

  wrc_wdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .ce(bus_ce), .hold(wdg_hold),
    .service(service), .expire(wdg_expire)
  );

  assign wdg_req = wdg_expire && wdg_enable;
  assign any_req = wdg_req || lv_s;

  wrc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ce(bus_ce), .req(any_req),
    .active(pulse_active), .rst_out_n(rst_out_n)
  );

  // Source flags and option bits: next-state logic.
  always_comb begin
    flags_d = flags_q;
    if (lv_s)          flags_d = '{wdg: 1'b0, lv: 1'b1};
    else if (wdg_req)  flags_d = '{wdg: 1'b1, lv: 1'b0};
    opt_d = opt_q;
    sec_d = sec_q;
    if (reg_hit) begin
      opt_d = wr_data[OPT_BIT];
      sec_d = wr_data[SEC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      opt_q   <= 1'b0;
      sec_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      opt_q   <= opt_d;
      sec_q   <= sec_d;
    end
  end

  assign src_wdg     = flags_q.wdg;
  assign src_lv      = flags_q.lv;
  assign opt_feat_en = opt_q;
  assign sec_lock    = sec_q;

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_enable && !lv_s && rst_out_n) |=> rst_out_n);
  a_r9_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_wdg, src_lv}));
  a_r9_flags_follow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> (src_wdg || src_lv));
  a_r10_options_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |=> $stable({opt_feat_en, sec_lock}));
  a_r6_lv_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    lv_s |=> !rst_out_n);
endmodule

// File: tb/wdg_rst_ctrl_test.sv
module wdg_rst_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 20;   // TIMEOUT_CYC for the bench
  localparam int CE_DIV     = 2;
  localparam int TO_CLK     = T * CE_DIV;

  logic        clk = 1'b0;
  logic        por_n, ext_rst_n, bus_ce, wr_en, wdg_enable, lv_detect;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        rst_out_n, src_wdg, src_lv, opt_feat_en, sec_lock;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  wdg_rst_ctrl #(.TIMEOUT_CYC(T)) uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .bus_ce(bus_ce),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wdg_enable(wdg_enable), .lv_detect(lv_detect),
    .rst_out_n(rst_out_n), .src_wdg(src_wdg), .src_lv(src_lv),
    .opt_feat_en(opt_feat_en), .sec_lock(sec_lock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus-cycle enable every CE_DIV clocks, changed away from the active edge.
  int ce_cnt = 0;
  always @(negedge clk) begin
    ce_cnt = (ce_cnt + 1) % CE_DIV;
    bus_ce = (ce_cnt == 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fall(input int limit, output int n);
    n = 0;
    while (rst_out_n && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (!rst_out_n && n < 500) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_lv(input int clks);
    @(negedge clk);
    lv_detect = 1'b1;
    repeat (clks) @(negedge clk);
    lv_detect = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset_state();
    do_por();
    check(rst_out_n == 1'b1, "R11 rst_out_n after por", rst_out_n, 1);
    check({src_wdg, src_lv, opt_feat_en, sec_lock} == 4'b0, "R11 flags/options after por",
          {src_wdg, src_lv, opt_feat_en, sec_lock}, 0);
  endtask

  task automatic test_service_keeps_alive();
    int n;
    wdg_enable = 1'b1;
    wr(16'h1FF0, 8'h00);
    n = 0;
    repeat (8) begin
      repeat (TO_CLK / 2) begin
        @(negedge clk);
        if (!rst_out_n) n++;
      end
      wr(16'h1FF0, 8'h00);
    end
    check(n == 0, "R2 periodic service prevents reset", n, 0);
  endtask

  task automatic test_timeout_and_width();
    int n, w;
    wr(16'h1FF0, 8'h00);
    wait_fall(4 * TO_CLK, n);
    check(n >= TO_CLK - 2 && n <= TO_CLK + 2, "R1 timeout clocks after service", n, TO_CLK);
    measure_low(w);
    check(w >= 3 * CE_DIV && w <= 4 * CE_DIV, "R4 watchdog pulse width", w, 4 * CE_DIV);
    check(src_wdg == 1'b1 && src_lv == 1'b0, "R9 watchdog source flag", {src_wdg, src_lv}, 2);
    // Count restarted at pulse end
    wait_fall(4 * TO_CLK, n);
    check(n >= TO_CLK - 2 && n <= TO_CLK + 2, "R8 restart after pulse", n, TO_CLK);
    measure_low(w);
  endtask

  task automatic test_ignored_writes();
    int n;
    bit fell;
    wr(16'h1FF0, 8'h00);
    n = 0; fell = 0;
    while (!fell && n < 4 * TO_CLK) begin
      @(negedge clk);
      n++;
      if (!rst_out_n) fell = 1;
      wr_en = (n == 10 || n == 20 || n == 30);
      wr_addr = (n == 20) ? 16'h1FF1 : (n == 30 ? 16'h0FF0 : 16'h1FF0);
      wr_data = (n == 10) ? 8'h01 : 8'h00;
    end
    wr_en = 1'b0;
    check(fell && n >= TO_CLK - 2 && n <= TO_CLK + 2,
          "R3 bit0=1 and other-address writes ignored", n, TO_CLK);
    measure_low(n);
  endtask

  task automatic test_disabled();
    int n;
    wdg_enable = 1'b0;
    wr(16'h1FF0, 8'h00);
    n = 0;
    repeat (3 * TO_CLK) begin
      @(negedge clk);
      if (!rst_out_n) n++;
    end
    check(n == 0, "R5 disabled watchdog never resets", n, 0);
  endtask

  task automatic test_low_voltage();
    int n, w;
    pulse_lv(1);
    wait_fall(10, n);
    check(n <= 4, "R6 low-voltage pulse latency", n, 2);
    measure_low(w);
    check(w >= 3 * CE_DIV && w <= 4 * CE_DIV, "R6 low-voltage pulse width", w, 4 * CE_DIV);
    check(src_lv == 1'b1 && src_wdg == 1'b0, "R9 low-voltage source flag", {src_wdg, src_lv}, 1);
    // Held low supply
    @(negedge clk);
    lv_detect = 1'b1;
    repeat (40) @(negedge clk);
    check(rst_out_n == 1'b0, "R6 held low supply keeps reset low", rst_out_n, 0);
    lv_detect = 1'b0;
    measure_low(w);
    check(w >= 3 * CE_DIV + 2 && w <= 4 * CE_DIV + 3, "R6 release after supply recovers",
          w, 4 * CE_DIV + 2);
  endtask

  task automatic test_extend();
    int n, w;
    pulse_lv(1);
    wait_fall(10, n);
    repeat (4) @(negedge clk);
    lv_detect = 1'b1;
    @(negedge clk);
    lv_detect = 1'b0;
    measure_low(w);
    w = w + 1;
    check(w >= 3 * CE_DIV + 2, "R7 request during pulse extends it", w, 3 * CE_DIV + 2);
  endtask

  task automatic test_ext_reset();
    int n;
    wdg_enable = 1'b1;
    wr(16'h1FF0, 8'h00);
    @(negedge clk);
    ext_rst_n = 1'b0;
    n = 0;
    repeat (3 * TO_CLK) begin
      @(negedge clk);
      if (!rst_out_n) n++;
    end
    check(n == 0, "R8 external reset holds watchdog", n, 0);
    ext_rst_n = 1'b1;
    wait_fall(4 * TO_CLK, n);
    check(n >= TO_CLK - 2 && n <= TO_CLK + 2, "R8 count restarts after external reset",
          n, TO_CLK);
    measure_low(n);
    wdg_enable = 1'b0;
  endtask

  task automatic test_options();
    int w;
    wr(16'h1FF0, 8'hC1);
    check(opt_feat_en == 1'b1 && sec_lock == 1'b1, "R10 option bits written",
          {sec_lock, opt_feat_en}, 3);
    pulse_lv(1);
    repeat (4) @(negedge clk);
    measure_low(w);
    check(opt_feat_en == 1'b1 && sec_lock == 1'b1, "R10 option bits survive pulse",
          {sec_lock, opt_feat_en}, 3);
    wr(16'h1FF0, 8'h40);
    check(opt_feat_en == 1'b1 && sec_lock == 1'b0, "R10 bit6 vs bit7 positions",
          {sec_lock, opt_feat_en}, 1);
    check(src_lv == 1'b1, "R9 flag persists across writes", src_lv, 1);
    do_por();
    check({src_wdg, src_lv, opt_feat_en, sec_lock} == 4'b0, "R9 por clears flags and options",
          {src_wdg, src_lv, opt_feat_en, sec_lock}, 0);
  endtask

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; bus_ce = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; wdg_enable = 1'b0; lv_detect = 1'b0;
    test_reset_state();
    test_service_keeps_alive();
    test_timeout_and_width();
    test_ignored_writes();
    test_disabled();
    test_low_voltage();
    test_extend();
    test_ext_reset();
    test_options();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule